// File: doc/BRIEF.md
# Channel Fault Diagnosis Register with General Fault Flag

This block collects raw fault indications for a group of low-side output channels (overload, open load and short to ground), filters each one through a per-channel persistence timer, and records a two-bit status code per channel once a fault has lasted long enough. The timer counts slow ticks made by dividing the system clock, so the delay can be set in microseconds whatever the clock rate.

The channels are split into banks of eight. A serial response path picks a bank with `rd_bank`. It then reads either the full two-bit-per-channel word or a one-bit-per-channel health byte. At the start of a serial frame it pulses `rd_strobe`, which clears the recorded codes of that bank only. The word shown during the strobe cycle is the record before the clear, so the response path captures it in the same cycle. An active-low general fault flag stays asserted while any channel holds a recorded fault. It can drive an open-drain interrupt line.

Top module: `chan_diag_reg`

## Requirements
- R1: Each channel code is 2 bits: 2'b11 healthy, 2'b10 overload (also short to supply or overtemperature), 2'b01 open load, 2'b00 short to ground. When several raw indications are active on one channel at once, overload wins over short to ground, which wins over open load.
- R2: `diag_word` shows the bank picked by `rd_bank` (bank b holds channels 8b to 8b+7). Channel 8b+k sits at bits 2k+1:2k, so the highest channel of the bank is at bits 15:14 and the lowest at bits 1:0.
- R3: A code is recorded only after its raw condition has been present, unchanged, for DELAY_TICKS timer ticks. One tick comes every TICK_DIV clocks. A shorter fault leaves the channel healthy.
- R4: A recorded code stays after the raw fault goes away. A different fault that later persists for the delay replaces it.
- R5: A one-cycle `rd_strobe` returns every channel of the bank picked by `rd_bank` to healthy on the next clock. `diag_word` shows the record before the clear during the strobe cycle, and the other bank is left unchanged.
- R6: `fault_n` is 0 while any channel holds a non-healthy code and 1 when every channel is healthy, including straight after reset.
- R7: `sum_byte` bit k is 1 when channel 8b+k of the selected bank is healthy and 0 for any recorded fault.
- R8: A fault still present when its bank is cleared is recorded again only after a fresh full delay counted from the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovl_det | input | NUM_CH | Raw overload / short-to-supply / overtemperature per channel |
| open_det | input | NUM_CH | Raw open-load indication per channel |
| gnd_det | input | NUM_CH | Raw short-to-ground indication per channel |
| rd_bank | input | BSEL_W | Bank selected for readout and clearing |
| rd_strobe | input | 1 | One-cycle read pulse; clears the selected bank |
| diag_word | output | 2*BANK_CH | Two-bit codes of the selected bank |
| sum_byte | output | BANK_CH | One health bit per channel of the selected bank |
| fault_n | output | 1 | Active-low general fault flag |

## Verification
The assertions assume that the raw fault inputs are already synchronous to `clk`, and that `rd_bank` always names an existing bank. They also assume `rd_strobe` is a single-cycle pulse and is not held high. The bench changes every input shortly after a rising edge. It selects only banks 0 and 1 and gives exactly one cycle of strobe per read. Its fault patterns include pulses shorter than the delay, simultaneous indications on one channel, and a fault held through a clear.

// File: rtl/diag_pkg.sv
package diag_pkg;

   typedef logic [1:0] diag_code_t;

   localparam diag_code_t CODE_OK   = 2'b11;
   localparam diag_code_t CODE_OVL  = 2'b10;
   localparam diag_code_t CODE_OPEN = 2'b01;
   localparam diag_code_t CODE_GND  = 2'b00;

   // Priority: overload, then short to ground, then open load.
   function automatic diag_code_t classify(input logic ovl, input logic gnd, input logic opn);
      if (ovl)      return CODE_OVL;
      else if (gnd) return CODE_GND;
      else if (opn) return CODE_OPEN;
      else          return CODE_OK;
   endfunction

endpackage

// File: rtl/diag_tick.sv
module diag_tick #(
   parameter int TICK_DIV = 100
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (TICK_DIV < 1) begin : g_bad
         $error("diag_tick: TICK_DIV must be at least 1");
      end

      if (TICK_DIV == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_div
         localparam int PW = $clog2(TICK_DIV);
         localparam logic [PW-1:0] PLAST = PW'(TICK_DIV - 1);
         logic [PW-1:0] pcnt_q;

         assign tick = (pcnt_q == PLAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    pcnt_q <= '0;
            else if (tick) pcnt_q <= '0;
            else           pcnt_q <= pcnt_q + 1'b1;
         end

         AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick); // R3
      end
   endgenerate
endmodule

// File: rtl/diag_filter.sv
module diag_filter
   import diag_pkg::*;
#(
   parameter int DELAY_TICKS = 100
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       clr,
   input  logic       ovl,
   input  logic       opn,
   input  logic       gnd,
   output diag_code_t code
);
   localparam int CNT_W = $clog2(DELAY_TICKS + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DELAY_TICKS);

   generate
      if (DELAY_TICKS < 1) begin : g_bad
         $error("diag_filter: DELAY_TICKS must be at least 1");
      end
   endgenerate

   diag_code_t       cand, cand_q, code_q;
   logic [CNT_W-1:0] cnt_q;
   logic             steady;

   always_comb begin
      cand   = classify(ovl, gnd, opn);
      steady = (cand == cand_q) && (cand != CODE_OK);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cand_q <= CODE_OK;
         cnt_q  <= '0;
         code_q <= CODE_OK;
      end else begin
         cand_q <= cand;
         if (clr || !steady)               cnt_q <= '0;
         else if (tick && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;

         if (clr)                          code_q <= CODE_OK;
         else if (steady && cnt_q == CNT_MAX) code_q <= cand;
      end
   end

   assign code = code_q;

   AST_HOLD_BEFORE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && cnt_q != CNT_MAX) |=> $stable(code_q)); // R3
   AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_MAX); // R3
   AST_CLEAR_HEALTHY: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (code_q == CODE_OK)); // R5
   AST_RELATCH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/chan_diag_reg.sv
module chan_diag_reg
   import diag_pkg::*;
#(
   parameter int NUM_CH      = 16,
   parameter int NUM_BANKS   = 2,
   parameter int TICK_DIV    = 100,
   parameter int DELAY_TICKS = 100,
   localparam int BANK_CH    = NUM_CH / NUM_BANKS,
   localparam int BSEL_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CH-1:0]    ovl_det,
   input  logic [NUM_CH-1:0]    open_det,
   input  logic [NUM_CH-1:0]    gnd_det,
   input  logic [BSEL_W-1:0]    rd_bank,
   input  logic                 rd_strobe,
   output logic [2*BANK_CH-1:0] diag_word,
   output logic [BANK_CH-1:0]   sum_byte,
   output logic                 fault_n
);
   generate
      if (NUM_BANKS < 1 || NUM_CH % NUM_BANKS != 0) begin : g_bad
         $error("chan_diag_reg: NUM_CH must split evenly into NUM_BANKS");
      end
   endgenerate

   logic                tick;
   logic [2*NUM_CH-1:0] codes_all;

   diag_tick #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         localparam int BANK = ch / BANK_CH;
         logic       clr;
         diag_code_t code;

         assign clr = rd_strobe && (rd_bank == BSEL_W'(BANK));

         diag_filter #(.DELAY_TICKS(DELAY_TICKS)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (tick),
            .clr  (clr),
            .ovl  (ovl_det[ch]),
            .opn  (open_det[ch]),
            .gnd  (gnd_det[ch]),
            .code (code)
         );

         assign codes_all[2*ch +: 2] = code;
      end
   endgenerate

   always_comb begin
      diag_word = {2*BANK_CH{1'b1}};
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (rd_bank == BSEL_W'(b)) diag_word = codes_all[2*BANK_CH*b +: 2*BANK_CH];
      end
   end

   always_comb begin
      for (int k = 0; k < BANK_CH; k++) sum_byte[k] = &diag_word[2*k +: 2];
   end

   assign fault_n = &codes_all;

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (!fault_n && !rd_strobe) |=> !fault_n); // R6
endmodule

// File: tb/chan_diag_reg_test.sv
module chan_diag_reg_test;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 16;
   localparam int BCH = 8;
   localparam int TD  = 4;
   localparam int DT  = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] ovl = '0, opn = '0, gnd = '0;
   logic        rd_bank = 1'b0;
   logic        rd_strobe = 1'b0;
   logic [15:0] diag_word;
   logic [7:0]  sum_byte;
   logic        fault_n;

   always #(CLK_PERIOD/2) clk = ~clk;

   chan_diag_reg #(.NUM_CH(NCH), .NUM_BANKS(2), .TICK_DIV(TD), .DELAY_TICKS(DT)) uut (
      .clk(clk), .rst_n(rst_n), .ovl_det(ovl), .open_det(opn), .gnd_det(gnd),
      .rd_bank(rd_bank), .rd_strobe(rd_strobe),
      .diag_word(diag_word), .sum_byte(sum_byte), .fault_n(fault_n));

   int    checks = 0, errors = 0;
   string req_tag = "R6";
   bit    done = 1'b0;

   // Behavioural reference state
   int m_code[NCH];
   int m_cnt[NCH];
   int m_cand[NCH];
   int m_pc;

   function automatic int prio(bit o, bit g, bit p);
      if (o) return 2;
      if (g) return 0;
      if (p) return 1;
      return 3;
   endfunction

   always @(posedge clk or negedge rst_n) begin : model
      bit tk;
      int c;
      bit clr;
      if (!rst_n) begin
         m_pc = 0;
         for (int i = 0; i < NCH; i++) begin m_code[i] = 3; m_cnt[i] = 0; m_cand[i] = 3; end
      end else begin
         tk = (m_pc == TD - 1);
         for (int i = 0; i < NCH; i++) begin
            c   = prio(ovl[i], gnd[i], opn[i]);
            clr = rd_strobe && ((i / BCH) == int'(rd_bank));
            if (clr) m_code[i] = 3;
            else if (c != 3 && c == m_cand[i] && m_cnt[i] == DT) m_code[i] = c;
            if (clr || c == 3 || c != m_cand[i]) m_cnt[i] = 0;
            else if (tk && m_cnt[i] < DT) m_cnt[i] = m_cnt[i] + 1;
            m_cand[i] = c;
         end
         m_pc = tk ? 0 : m_pc + 1;
      end
   end

   function automatic logic [15:0] exp_word();
      logic [15:0] w;
      for (int k = 0; k < BCH; k++) w[2*k +: 2] = 2'(m_code[int'(rd_bank)*BCH + k]);
      return w;
   endfunction

   function automatic logic [7:0] exp_sum();
      logic [7:0] s;
      for (int k = 0; k < BCH; k++) s[k] = (m_code[int'(rd_bank)*BCH + k] == 3);
      return s;
   endfunction

   function automatic logic exp_flag();
      for (int i = 0; i < NCH; i++) if (m_code[i] != 3) return 1'b0;
      return 1'b1;
   endfunction

   task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(req_tag, "diag_word", diag_word, exp_word());
         chk("R7", "sum_byte", {8'h00, sum_byte}, {8'h00, exp_sum()});
         chk("R6", "fault_n", {15'h0, fault_n}, {15'h0, exp_flag()});
      end
   end

   task automatic drive(logic [15:0] o, logic [15:0] p, logic [15:0] g);
      @(posedge clk); #1;
      ovl = o; opn = p; gnd = g;
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic sel(logic b);
      @(posedge clk); #1;
      rd_bank = b;
   endtask

   task automatic strobe(logic [15:0] pre, logic [15:0] post, string tag);
      @(posedge clk); #1;
      rd_strobe = 1'b1;
      @(negedge clk);
      chk(tag, "word during strobe", diag_word, pre);
      @(posedge clk); #1;
      rd_strobe = 1'b0;
      @(negedge clk);
      chk(tag, "word after strobe", diag_word, post);
   endtask

   task automatic dchk(string tag, logic [15:0] w, logic [7:0] s, logic f);
      @(negedge clk);
      chk(tag, "word", diag_word, w);
      chk(tag, "sum", {8'h00, sum_byte}, {8'h00, s});
      chk(tag, "flag", {15'h0, fault_n}, {15'h0, f});
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R6", "reset word", diag_word, 16'hFFFF);
      chk("R6", "reset flag", {15'h0, fault_n}, 16'h0001);
      @(posedge clk); #1;
      rst_n = 1'b1;

      // R3: a pulse shorter than the delay leaves the channel healthy
      req_tag = "R3";
      drive(16'h0000, 16'h0004, 16'h0000);
      wait_cyc(8);
      drive('0, '0, '0);
      wait_cyc(40);
      dchk("R3", 16'hFFFF, 8'hFF, 1'b1);

      // R1 / R2: code values, priority and field placement in bank 0
      req_tag = "R1";
      drive(16'h0021, 16'h0068, 16'h00C0);
      wait_cyc(40);
      dchk("R1", 16'h0B7E, 8'h16, 1'b0);
      dchk("R2", 16'h0B7E, 8'h16, 1'b0);

      // R4: record held after release, then overwritten by a new fault
      req_tag = "R4";
      drive('0, '0, '0);
      wait_cyc(20);
      dchk("R4", 16'h0B7E, 8'h16, 1'b0);
      drive(16'h0008, '0, '0);
      wait_cyc(40);
      drive('0, '0, '0);
      dchk("R4", 16'h0BBE, 8'h16, 1'b0);

      // R2 / R7: second bank
      req_tag = "R2";
      drive('0, 16'h0200, '0);
      wait_cyc(40);
      drive('0, '0, '0);
      sel(1'b1);
      dchk("R2", 16'hFFF7, 8'hFD, 1'b0);
      dchk("R7", 16'hFFF7, 8'hFD, 1'b0);

      // R5: clear of the selected bank only
      req_tag = "R5";
      sel(1'b0);
      strobe(16'h0BBE, 16'hFFFF, "R5");
      sel(1'b1);
      dchk("R5", 16'hFFF7, 8'hFD, 1'b0);
      strobe(16'hFFF7, 16'hFFFF, "R5");
      dchk("R6", 16'hFFFF, 8'hFF, 1'b1);

      // R8: a held fault re-latches only after a fresh delay
      req_tag = "R8";
      drive(16'h1000, '0, '0);
      wait_cyc(40);
      dchk("R8", 16'hFEFF, 8'hEF, 1'b0);
      strobe(16'hFEFF, 16'hFFFF, "R8");
      wait_cyc(10);
      dchk("R8", 16'hFFFF, 8'hFF, 1'b1);
      wait_cyc(40);
      dchk("R8", 16'hFEFF, 8'hEF, 1'b0);
      drive('0, '0, '0);
      strobe(16'hFEFF, 16'hFFFF, "R8");
      dchk("R6", 16'hFFFF, 8'hFF, 1'b1);

      wait_cyc(2);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule